// File: doc/BRIEF.md
# PTP Target Time Comparator

This block watches a free-running precision-time value. The value arrives as a seconds word and a subseconds word from a system time counter outside the block. Software loads a target time into the block's own target registers. The block raises a sticky "target reached" status the first time the running time climbs to or past that target.

A two-bit trigger mode is sampled at the moment of the hit. It decides whether the hit produces an interrupt, a start command for a pulse-per-second stage, a stop command for that stage, or a combination of these. The interrupt is additionally gated by an enable.

The block also keeps a sticky flag that records a wrap of the seconds word past its all-ones value. Both sticky flags and the pending interrupt are cleared by a single clear pulse. When nanosecond (digital) subsecond rollover is selected, a target subseconds value above the nanosecond ceiling can never be reached by the counter. Such a target is treated as never matching.

Top module: `ptp_target_cmp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all outputs are low. The target seconds and subseconds registers reset to zero, so a running time of zero matches the reset target.
- R2: Time and target are compared as one unsigned 64-bit value, seconds in the upper 32 bits and subseconds in the lower 32 bits. The hit condition is time ≥ target. `tgt_reached` rises two clock edges after the edge at which the matching time sample is taken.
- R3: A hit is taken only on the rising edge of the registered compare. While time stays at or above the target, a cleared `tgt_reached` stays clear. Time must fall below the target and climb again to produce a new hit.
- R4: `tgt_reached` stays set until a `status_clr` pulse. If a new hit and `status_clr` fall in the same cycle, the flag ends up set.
- R5: `irq` becomes set on a hit only when `irq_en` is 1 and `trig_mode` is 00 or 01 in the hit cycle. It stays set until `status_clr`, and a hit in the same cycle as the clear wins.
- R6: On a hit, `pps_start` is a one-cycle pulse for `trig_mode` 01 or 10, and `pps_stop` is a one-cycle pulse for `trig_mode` 11. Mode 00 pulses neither. The two pulses are never high together, and each one coincides with `tgt_reached` being set.
- R7: With `digital_roll` = 1, a target subseconds value above 0x3B9A_C9FF never matches, whatever the seconds. A value equal to 0x3B9A_C9FF matches normally. With `digital_roll` = 0, any value can match.
- R8: `sec_ovf` becomes set two edges after the edge that samples `time_sec` = 0, when the previous sample was 0xFFFF_FFFF. Any other transition to zero leaves it clear. It is sticky until `status_clr`.
- R9: One `tgt_wr` cycle loads both target words. The new target governs the compare at the next edge, so a resulting hit appears on `tgt_reached` two edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_sec | input | 32 | Running time, seconds |
| time_sub | input | 32 | Running time, subseconds |
| tgt_wr | input | 1 | Load strobe for both target words |
| tgt_sec_in | input | 32 | Target seconds to load |
| tgt_sub_in | input | 32 | Target subseconds to load |
| digital_roll | input | 1 | 1 = nanosecond subsecond rollover (ceiling enforced) |
| trig_mode | input | 2 | 00 irq, 01 irq+start, 10 start, 11 stop |
| irq_en | input | 1 | Interrupt enable |
| status_clr | input | 1 | Clear pulse for flags and pending interrupt |
| tgt_reached | output | 1 | Sticky target-reached status |
| sec_ovf | output | 1 | Sticky seconds-wrap status |
| irq | output | 1 | Pending target interrupt |
| pps_start | output | 1 | One-cycle start command to the pulse stage |
| pps_stop | output | 1 | One-cycle stop command to the pulse stage |

## Verification
Two events can meet in one cycle: a fresh compare hit and the clear pulse meant for the previous one. The bench provokes this by lifting the time above the target and raising `status_clr` exactly one cycle later, when the hit is being registered. `tgt_reached` and `irq` must come out set. A cycle-accurate reference built from the requirements follows every sweep of mode, enable and time offset around the target, so a clear landing beside a seconds wrap is also judged.

// File: rtl/ptp_tgt_pkg.sv
package ptp_tgt_pkg;

  typedef enum logic [1:0] {
    TRIG_IRQ       = 2'b00,
    TRIG_IRQ_START = 2'b01,
    TRIG_START     = 2'b10,
    TRIG_STOP      = 2'b11
  } trig_mode_e;

  typedef struct packed {
    logic want_irq;
    logic want_start;
    logic want_stop;
  } trig_act_t;

  function automatic trig_act_t decode_trig(trig_mode_e m);
    trig_act_t a;
    a = '0;
    case (m)
      TRIG_IRQ:       a.want_irq = 1'b1;
      TRIG_IRQ_START: begin
        a.want_irq   = 1'b1;
        a.want_start = 1'b1;
      end
      TRIG_START:     a.want_start = 1'b1;
      TRIG_STOP:      a.want_stop = 1'b1;
      default:        a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/ptp_tgt_regs.sv
module ptp_tgt_regs #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEC_W-1:0] sec_in,
  input  logic [SUB_W-1:0] sub_in,
  output logic [SEC_W-1:0] tgt_sec,
  output logic [SUB_W-1:0] tgt_sub
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_sec <= '0;
      tgt_sub <= '0;
    end else if (wr) begin
      tgt_sec <= sec_in;
      tgt_sub <= sub_in;
    end
  end

endmodule

// File: rtl/ptp_tgt_compare.sv
module ptp_tgt_compare #(
  parameter int             SEC_W   = 32,
  parameter int             SUB_W   = 32,
  parameter bit             CEIL_EN = 1'b1,
  parameter logic [SUB_W-1:0] NS_CEIL = 32'h3B9A_C9FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] time_sec,
  input  logic [SUB_W-1:0] time_sub,
  input  logic [SEC_W-1:0] tgt_sec,
  input  logic [SUB_W-1:0] tgt_sub,
  input  logic             digital_roll,
  output logic             cmp_ge,
  output logic             cmp_rise
);

  localparam int TOT_W = SEC_W + SUB_W;

  logic [TOT_W-1:0] now_v;
  logic [TOT_W-1:0] tgt_v;
  logic             tgt_legal;
  logic             ge_q;
  logic             ge_d;

  assign now_v = {time_sec, time_sub};
  assign tgt_v = {tgt_sec, tgt_sub};

  generate
    if (CEIL_EN) begin : g_ceil
      assign tgt_legal = !(digital_roll && (tgt_sub > NS_CEIL));
    end else begin : g_noceil
      assign tgt_legal = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ge_q <= 1'b0;
      ge_d <= 1'b0;
    end else begin
      ge_q <= tgt_legal && (now_v >= tgt_v);
      ge_d <= ge_q;
    end
  end

  assign cmp_ge   = ge_q;
  assign cmp_rise = ge_q & ~ge_d;

endmodule

// File: rtl/ptp_sec_wrap.sv
module ptp_sec_wrap #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] time_sec,
  output logic             wrap
);

  logic [SEC_W-1:0] prev_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      valid_q <= 1'b0;
      wrap    <= 1'b0;
    end else begin
      wrap    <= valid_q && (&prev_q) && (time_sec == '0);
      prev_q  <= time_sec;
      valid_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ptp_tgt_action.sv
module ptp_tgt_action
  import ptp_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic       wrap,
  input  trig_mode_e mode,
  input  logic       irq_en,
  input  logic       clr,
  output logic       reached,
  output logic       ovf,
  output logic       irq,
  output logic       start,
  output logic       stop
);

  trig_act_t act;

  always_comb act = decode_trig(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      reached <= 1'b0;
      ovf     <= 1'b0;
      irq     <= 1'b0;
      start   <= 1'b0;
      stop    <= 1'b0;
    end else begin
      reached <= hit | (reached & ~clr);
      ovf     <= wrap | (ovf & ~clr);
      irq     <= (hit & irq_en & act.want_irq) | (irq & ~clr);
      start   <= hit & act.want_start;
      stop    <= hit & act.want_stop;
    end
  end

endmodule

// File: rtl/ptp_target_cmp.sv
module ptp_target_cmp
  import ptp_tgt_pkg::*;
#(
  parameter int               SEC_W   = 32,
  parameter int               SUB_W   = 32,
  parameter bit               CEIL_EN = 1'b1,
  parameter logic [SUB_W-1:0] NS_CEIL = 32'h3B9A_C9FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] time_sec,
  input  logic [SUB_W-1:0] time_sub,
  input  logic             tgt_wr,
  input  logic [SEC_W-1:0] tgt_sec_in,
  input  logic [SUB_W-1:0] tgt_sub_in,
  input  logic             digital_roll,
  input  logic [1:0]       trig_mode,
  input  logic             irq_en,
  input  logic             status_clr,
  output logic             tgt_reached,
  output logic             sec_ovf,
  output logic             irq,
  output logic             pps_start,
  output logic             pps_stop
);

  logic [SEC_W-1:0] tgt_sec_q;
  logic [SUB_W-1:0] tgt_sub_q;
  logic             cmp_ge;
  logic             cmp_rise;
  logic             sec_wrap;
  trig_mode_e       mode_e;

  assign mode_e = trig_mode_e'(trig_mode);

  ptp_tgt_regs #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (tgt_wr),
    .sec_in  (tgt_sec_in),
    .sub_in  (tgt_sub_in),
    .tgt_sec (tgt_sec_q),
    .tgt_sub (tgt_sub_q)
  );

  ptp_tgt_compare #(
    .SEC_W(SEC_W), .SUB_W(SUB_W), .CEIL_EN(CEIL_EN), .NS_CEIL(NS_CEIL)
  ) u_cmp (
    .clk          (clk),
    .rst          (rst),
    .time_sec     (time_sec),
    .time_sub     (time_sub),
    .tgt_sec      (tgt_sec_q),
    .tgt_sub      (tgt_sub_q),
    .digital_roll (digital_roll),
    .cmp_ge       (cmp_ge),
    .cmp_rise     (cmp_rise)
  );

  ptp_sec_wrap #(.SEC_W(SEC_W)) u_wrap (
    .clk      (clk),
    .rst      (rst),
    .time_sec (time_sec),
    .wrap     (sec_wrap)
  );

  ptp_tgt_action u_act (
    .clk     (clk),
    .rst     (rst),
    .hit     (cmp_rise),
    .wrap    (sec_wrap),
    .mode    (mode_e),
    .irq_en  (irq_en),
    .clr     (status_clr),
    .reached (tgt_reached),
    .ovf     (sec_ovf),
    .irq     (irq),
    .start   (pps_start),
    .stop    (pps_stop)
  );

endmodule

// File: rtl/ptp_target_cmp_chk.sv
module ptp_target_cmp_chk #(
  parameter int               SUB_W   = 32,
  parameter logic [SUB_W-1:0] NS_CEIL = 32'h3B9A_C9FF
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_en,
  input logic             digital_roll,
  input logic             status_clr,
  input logic [SUB_W-1:0] tgt_sub_q,
  input logic             cmp_ge,
  input logic             cmp_rise,
  input logic             sec_wrap,
  input logic             tgt_reached,
  input logic             sec_ovf,
  input logic             irq,
  input logic             pps_start,
  input logic             pps_stop
);

  // R6
  pps_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pps_start && pps_stop));

  // R6
  pps_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (pps_start || pps_stop) |-> tgt_reached);

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(irq_en));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_reached && !status_clr) |=> tgt_reached);

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (status_clr && !cmp_rise) |=> !tgt_reached);

  // R3
  rise_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_reached) |-> $past(cmp_rise));

  // R7
  ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (digital_roll && (tgt_sub_q > NS_CEIL)) |=> !cmp_ge);

  // R8
  ovf_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_ovf) |-> $past(sec_wrap));

endmodule

bind ptp_target_cmp ptp_target_cmp_chk #(
  .SUB_W(SUB_W), .NS_CEIL(NS_CEIL)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_en       (irq_en),
  .digital_roll (digital_roll),
  .status_clr   (status_clr),
  .tgt_sub_q    (tgt_sub_q),
  .cmp_ge       (cmp_ge),
  .cmp_rise     (cmp_rise),
  .sec_wrap     (sec_wrap),
  .tgt_reached  (tgt_reached),
  .sec_ovf      (sec_ovf),
  .irq          (irq),
  .pps_start    (pps_start),
  .pps_stop     (pps_stop)
);

// File: tb/ptp_target_cmp_bench.sv
module ptp_target_cmp_bench;

  localparam logic [31:0] CEIL = 32'h3B9A_C9FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] time_sec = '0, time_sub = '0;
  logic        tgt_wr = 1'b0;
  logic [31:0] tgt_sec_in = '0, tgt_sub_in = '0;
  logic        digital_roll = 1'b0;
  logic [1:0]  trig_mode = 2'b00;
  logic        irq_en = 1'b0;
  logic        status_clr = 1'b0;
  logic        tgt_reached, sec_ovf, irq, pps_start, pps_stop;

  always #5 clk = ~clk;

  ptp_target_cmp u_ptp_target_cmp (
    .clk(clk), .rst(rst), .time_sec(time_sec), .time_sub(time_sub),
    .tgt_wr(tgt_wr), .tgt_sec_in(tgt_sec_in), .tgt_sub_in(tgt_sub_in),
    .digital_roll(digital_roll), .trig_mode(trig_mode), .irq_en(irq_en),
    .status_clr(status_clr), .tgt_reached(tgt_reached), .sec_ovf(sec_ovf),
    .irq(irq), .pps_start(pps_start), .pps_stop(pps_stop)
  );

  int    total = 0;
  int    bad = 0;
  string phase = "R1";

  // reference state, built from the requirements
  logic [63:0] m_tgt;
  logic        m_ge, m_gep, m_wrap, m_pv;
  logic [31:0] m_ps;
  logic        m_reached, m_ovf, m_irq, m_start, m_stop;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s) act=%0h exp=%0h", what, phase, act, exp);
    end
  endtask

  task automatic tick();
    logic rise, legal;
    @(posedge clk);
    if (rst) begin
      m_tgt = '0; m_ge = 0; m_gep = 0; m_wrap = 0; m_pv = 0; m_ps = '0;
      m_reached = 0; m_ovf = 0; m_irq = 0; m_start = 0; m_stop = 0;
    end else begin
      rise      = m_ge && !m_gep;
      legal     = !(digital_roll && (m_tgt[31:0] > CEIL));
      m_reached = rise | (m_reached & ~status_clr);
      m_ovf     = m_wrap | (m_ovf & ~status_clr);
      m_irq     = (rise & irq_en & (trig_mode < 2)) | (m_irq & ~status_clr);
      m_start   = rise & ((trig_mode == 2'd1) || (trig_mode == 2'd2));
      m_stop    = rise & (trig_mode == 2'd3);
      m_gep     = m_ge;
      m_ge      = legal && ({time_sec, time_sub} >= m_tgt);
      m_wrap    = m_pv && (time_sec == 32'hFFFF_FFFF) ? (time_sec == 32'h0) : 1'b0;
      m_wrap    = m_pv && (m_ps == 32'hFFFF_FFFF) && (time_sec == 32'h0);
      m_ps      = time_sec;
      m_pv      = 1'b1;
      if (tgt_wr) m_tgt = {tgt_sec_in, tgt_sub_in};
    end
    @(negedge clk);
    chk("R2 tgt_reached", 32'(tgt_reached), 32'(m_reached));
    chk("R8 sec_ovf",     32'(sec_ovf),     32'(m_ovf));
    chk("R5 irq",         32'(irq),         32'(m_irq));
    chk("R6 pps_start",   32'(pps_start),   32'(m_start));
    chk("R6 pps_stop",    32'(pps_stop),    32'(m_stop));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_time(logic [31:0] s, logic [31:0] u);
    time_sec = s;
    time_sub = u;
  endtask

  task automatic write_tgt(logic [31:0] s, logic [31:0] u);
    tgt_sec_in = s; tgt_sub_in = u; tgt_wr = 1'b1;
    tick();
    tgt_wr = 1'b0;
  endtask

  task automatic clear();
    status_clr = 1'b1;
    tick();
    status_clr = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state and zero target
    phase = "R1";
    ticks(3);
    chk("R1 reset tgt_reached", 32'(tgt_reached), 0);
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset pps_start", 32'(pps_start), 0);
    rst = 1'b0;
    tick();
    chk("R1 first cycle flag", 32'(tgt_reached), 0);
    tick();
    chk("R1 zero target matched", 32'(tgt_reached), 1);

    // R9: write effect timing
    phase = "R9";
    set_time(3, 0);
    write_tgt(100, 0);
    ticks(2);
    clear();
    ticks(2);
    write_tgt(3, 0);
    tick();
    chk("R9 one edge after write", 32'(tgt_reached), 0);
    tick();
    chk("R9 two edges after write", 32'(tgt_reached), 1);

    // R2/R5/R6 sweep over mode, enable and offset
    phase = "R2 sweep";
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int d = -2; d <= 2; d++) begin
          trig_mode = 2'(m);
          irq_en = 1'(e);
          set_time(0, 0);
          write_tgt(7, 32'h8000_0000);
          ticks(2);
          clear();
          set_time(6, 32'hFFFF_FFFF);
          ticks(2);
          set_time(7, 32'(32'h8000_0000 + d));
          ticks(3);
          chk("R2 offset result", 32'(tgt_reached), 32'(d >= 0));
          chk("R5 irq result", 32'(irq), 32'((d >= 0) && e == 1 && m < 2));
        end
      end
    end

    // R2: seconds dominate the subseconds
    phase = "R2 order";
    trig_mode = 2'd0; irq_en = 1'b1;
    set_time(0, 0);
    ticks(2);
    clear();
    set_time(8, 0);
    ticks(3);
    chk("R2 higher seconds lower sub", 32'(tgt_reached), 1);

    // R3: no re-hit while staying above
    phase = "R3";
    set_time(9, 0);
    ticks(2);
    clear();
    ticks(4);
    chk("R3 no retrigger", 32'(tgt_reached), 0);
    set_time(0, 0);
    ticks(2);
    set_time(9, 0);
    ticks(3);
    chk("R3 retrigger after dip", 32'(tgt_reached), 1);

    // R4: clear and hit in the same cycle
    phase = "R4";
    set_time(0, 0);
    ticks(2);
    clear();
    set_time(9, 0);
    tick();
    status_clr = 1'b1;
    tick();
    status_clr = 1'b0;
    chk("R4 hit beats clear", 32'(tgt_reached), 1);
    chk("R5 irq hit beats clear", 32'(irq), 1);
    ticks(2);
    chk("R4 sticky", 32'(tgt_reached), 1);
    clear();
    chk("R4 cleared", 32'(tgt_reached), 0);

    // R7: nanosecond ceiling
    phase = "R7";
    trig_mode = 2'd3;
    digital_roll = 1'b1;
    set_time(0, 0);
    write_tgt(7, 32'h3B9A_CA00);
    ticks(2);
    clear();
    set_time(20, 32'hFFFF_FFFF);
    ticks(4);
    chk("R7 above ceiling never hits", 32'(tgt_reached), 0);
    digital_roll = 1'b0;
    ticks(3);
    chk("R7 binary mode hits", 32'(tgt_reached), 1);
    digital_roll = 1'b1;
    set_time(0, 0);
    write_tgt(7, CEIL);
    ticks(2);
    clear();
    set_time(7, CEIL);
    ticks(3);
    chk("R7 at ceiling hits", 32'(tgt_reached), 1);
    digital_roll = 1'b0;

    // R8: seconds wrap
    phase = "R8";
    clear();
    set_time(32'hFFFF_FFFE, 0); tick();
    set_time(32'hFFFF_FFFF, 0); tick();
    set_time(0, 0); tick();
    chk("R8 one edge after zero", 32'(sec_ovf), 0);
    tick();
    chk("R8 wrap flagged", 32'(sec_ovf), 1);
    ticks(2);
    clear();
    chk("R8 cleared", 32'(sec_ovf), 0);
    set_time(32'hFFFF_FFFF, 0); tick();
    set_time(5, 0); tick();
    set_time(0, 0); ticks(3);
    chk("R8 no wrap on other zero", 32'(sec_ovf), 0);

    summary();
    $finish;
  end

endmodule